// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block watches twelve asynchronous interrupt pins. Each pin has its own edge-direction select. When the chosen edge appears on a pin, the block sets a sticky flag for that line. Every flag is masked by an enable bit, and the unmasked flags are combined into one registered interrupt request to the processor.

Software reaches the flags and enables through a small register bus. The bus has an address, a write strobe and byte-wide write data, and the read data is combinational. Lines 0 to 7 occupy one flag byte and one enable byte. Lines 8 to 11 occupy the low nibble of a second pair of bytes.

Flags are set by hardware and cleared only by software. Software can also write a 1 to a flag, and this raises an interrupt in the same way a pin edge would. Edge detection compares successive synchronised pin samples, so changing the direction select can never create an edge on its own.

Top module: `eic_top`

## Requirements
- R1: When a line's direction select bit is 1, a high-to-low transition on its pin sets that line's flag. The flag becomes readable no later than 3 clock edges after the pin changes.
- R2: When a line's direction select bit is 0, a low-to-high transition on its pin sets that line's flag. The flag becomes readable no later than 3 clock edges after the pin changes.
- R3: A transition in the direction opposite to the line's select bit leaves the flag clear.
- R4: A set flag stays set until software writes 0 to its bit or reset is asserted. A written 0 clears the flag.
- R5: Writing 1 to a flag bit sets that flag. If the line is enabled, this raises the interrupt request.
- R6: Clearing a line's enable bit keeps its flag from raising the interrupt request. Hardware still sets the flag.
- R7: Synchronous active-high reset clears every flag and every enable bit, and drives the interrupt request low.
- R8: Register map, by address:
  - 0: flags of lines 7..0, with bit n for line n.
  - 1: enables of lines 7..0, with bit n for line n.
  - 2: flags of lines 11..8 in bits 3:0.
  - 3: enables of lines 11..8 in bits 3:0.
  In addresses 2 and 3, bits 7:4 always read 0 and ignore writes.
- R9: The interrupt request is the OR of flag AND enable over all lines, delayed by exactly one register stage.
- R10: If a hardware edge sets a flag in the same clock cycle that software writes 0 to that flag, the flag ends up set.
- R11: Changing a direction select bit while the pin is steady does not set the flag.
- R12: Addresses 4 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 12 | Asynchronous interrupt pins, bit n is line n |
| edge_sel_i | input | 12 | Per-line edge direction: 1 = high-to-low, 0 = low-to-high |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A vector table drives the main edge-detection function. It covers lines in both register bytes, both direction settings, and both transition directions, so a matching edge and an opposing edge can be told apart.

Directed cases cover the remaining rules:
- A software-written flag with the enable on and with the enable off, which separates the flag store from the masking logic.
- A write of 0 that lands in the same cycle as a pin edge, which shows whether set or clear wins.
- A direction flip on a steady pin, which would reveal any edge detection driven by the select bit.
- All-ones writes to the upper registers, followed by reads of the unmapped addresses.

// File: rtl/eic_pkg.sv
package eic_pkg;

    parameter int NUM_LINES  = 12;
    parameter int REG_W      = 8;
    parameter int ADDR_W     = 3;
    parameter int SYNC_DEPTH = 2;

    localparam int NUM_BANKS = (NUM_LINES + REG_W - 1) / REG_W;
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int MAPPED    = 2 * NUM_BANKS;

    typedef enum logic {
        KIND_FLAG   = 1'b0,
        KIND_ENABLE = 1'b1
    } reg_kind_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  wdata;
    } bus_req_t;

    typedef struct packed {
        logic              mapped;
        logic [BANK_W-1:0] bank;
        reg_kind_e         kind;
    } reg_dec_t;

    // Even offsets hold flags, odd offsets hold enables, one pair per bank.
    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] addr);
        reg_dec_t d;
        d.mapped = (int'(addr) < MAPPED);
        d.bank   = BANK_W'(addr >> 1);
        d.kind   = reg_kind_e'(addr[0]);
        return d;
    endfunction

    function automatic int bank_width(input int bank);
        int rest;
        rest = NUM_LINES - bank * REG_W;
        return (rest > REG_W) ? REG_W : rest;
    endfunction

endpackage

// File: rtl/eic_pin_sync.sv
module eic_pin_sync #(
    parameter int WIDTH  = eic_pkg::NUM_LINES,
    parameter int STAGES = eic_pkg::SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/eic_edge_detect.sv
module eic_edge_detect #(
    parameter int WIDTH  = eic_pkg::NUM_LINES,
    parameter int STAGES = eic_pkg::SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] sample_i,
    input  logic [WIDTH-1:0] falling_sel_i,
    output logic [WIDTH-1:0] edge_hit_o
);

    // Pipeline fill after reset: sync stages plus the previous-sample stage.
    localparam int ARM_LEN = STAGES + 1;

    logic [WIDTH-1:0]   prev_q;
    logic [ARM_LEN-1:0] arm_q;
    logic               armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            arm_q  <= '0;
        end else begin
            prev_q <= sample_i;
            arm_q  <= {arm_q[ARM_LEN-2:0], 1'b1};
        end
    end

    assign armed = arm_q[ARM_LEN-1];

    // Only pin samples are compared; the select bit merely picks a direction.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_line
            logic rise, fall;
            assign rise          = sample_i[i] & ~prev_q[i];
            assign fall          = ~sample_i[i] & prev_q[i];
            assign edge_hit_o[i] = armed & (falling_sel_i[i] ? fall : rise);
        end
    endgenerate

endmodule

// File: rtl/eic_flag_bank.sv
module eic_flag_bank
    import eic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  bus_req_t             req_i,
    input  logic [NUM_LINES-1:0] set_hw_i,
    output logic [NUM_LINES-1:0] flags_o,
    output logic [NUM_LINES-1:0] enables_o,
    output logic [REG_W-1:0]     rdata_o
);

    reg_dec_t               dec;
    logic [REG_W-1:0]       flag_rd [NUM_BANKS];
    logic [REG_W-1:0]       en_rd   [NUM_BANKS];

    assign dec = decode_addr(req_i.addr);

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam int BW   = bank_width(b);
            localparam int BASE = b * REG_W;

            logic [BW-1:0] flag_q, en_q, flag_d;
            logic          wr_flag, wr_en, hit;

            assign hit     = req_i.we && dec.mapped && (dec.bank == BANK_W'(b));
            assign wr_flag = hit && (dec.kind == KIND_FLAG);
            assign wr_en   = hit && (dec.kind == KIND_ENABLE);

            // Hardware set is OR'd after the write, so an edge beats a clear.
            assign flag_d = (wr_flag ? req_i.wdata[BW-1:0] : flag_q)
                          | set_hw_i[BASE +: BW];

            always_ff @(posedge clk) begin
                if (rst) begin
                    flag_q <= '0;
                    en_q   <= '0;
                end else begin
                    flag_q <= flag_d;
                    if (wr_en) en_q <= req_i.wdata[BW-1:0];
                end
            end

            assign flags_o[BASE +: BW]   = flag_q;
            assign enables_o[BASE +: BW] = en_q;
            assign flag_rd[b]            = REG_W'(flag_q);
            assign en_rd[b]              = REG_W'(en_q);
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        if (dec.mapped) begin
            if (dec.kind == KIND_FLAG) rdata_o = flag_rd[dec.bank];
            else                       rdata_o = en_rd[dec.bank];
        end
    end

endmodule

// File: rtl/eic_top.sv
module eic_top
    import eic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] pins_i,
    input  logic [NUM_LINES-1:0] edge_sel_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 we_i,
    input  logic [REG_W-1:0]     wdata_i,
    output logic [REG_W-1:0]     rdata_o,
    output logic                 irq_o
);

    logic [NUM_LINES-1:0] pin_sync;
    logic [NUM_LINES-1:0] edge_hit;
    logic [NUM_LINES-1:0] line_flags;
    logic [NUM_LINES-1:0] line_enables;
    bus_req_t             req;
    logic                 irq_q;

    assign req = '{we: we_i, addr: addr_i, wdata: wdata_i};

    eic_pin_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pins_i),
        .sync_o  (pin_sync)
    );

    eic_edge_detect #(.WIDTH(NUM_LINES), .STAGES(SYNC_DEPTH)) u_edge (
        .clk           (clk),
        .rst           (rst),
        .sample_i      (pin_sync),
        .falling_sel_i (edge_sel_i),
        .edge_hit_o    (edge_hit)
    );

    eic_flag_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .set_hw_i  (edge_hit),
        .flags_o   (line_flags),
        .enables_o (line_enables),
        .rdata_o   (rdata_o)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(line_flags & line_enables);
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/eic_checker.sv
module eic_checker
    import eic_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    addr_i,
    input logic                 we_i,
    input logic [REG_W-1:0]     rdata_o,
    input logic                 irq_o,
    input logic [NUM_LINES-1:0] flags,
    input logic [NUM_LINES-1:0] enables,
    input logic [NUM_LINES-1:0] edge_hit
);

    localparam int HI_W = NUM_LINES - REG_W;

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> ((flags & $past(flags)) == $past(flags)));

    // R1
    edge_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (|edge_hit) |=> ((flags & $past(edge_hit)) == $past(edge_hit)));

    // R9
    irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == |($past(flags) & $past(enables))));

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (enables == '0) |=> !irq_o);

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_i == ADDR_W'(2) || addr_i == ADDR_W'(3))
            |-> (rdata_o[REG_W-1:HI_W] == '0));

    // R12
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(addr_i) >= MAPPED) |-> (rdata_o == '0));

endmodule

bind eic_top eic_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o),
    .flags    (line_flags),
    .enables  (line_enables),
    .edge_hit (edge_hit)
);

// File: tb/tb_eic_top.sv
module tb_eic_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] pins = '0;
    logic [11:0] esel = '0;
    logic [2:0]  addr = '0;
    logic        we = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    eic_top dut (
        .clk(clk), .rst(rst), .pins_i(pins), .edge_sel_i(esel),
        .addr_i(addr), .we_i(we), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    always #4 clk = ~clk;

    // {line[3:0], select, start level, end level, expected flag}
    localparam logic [7:0] VECS [0:7] = '{
        8'h03, 8'h1D, 8'h24, 8'h3A, 8'h93, 8'hBD, 8'h7D, 8'h84
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic clear_all();
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(4);

        // R7: reset state
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v);
            check("R7", v, 8'h00);
        end
        check("R7", {7'b0, irq}, 8'h00);

        // Vector walk: R1, R2, R3 (enables off, so R6 irq stays low)
        for (int i = 0; i < 8; i++) begin
            logic [3:0] ln;
            logic [7:0] exp;
            ln = VECS[i][7:4];
            esel = '0;
            esel[ln] = VECS[i][3];
            pins = '0;
            pins[ln] = VECS[i][2];
            idle(6);
            wr(3'd0, 8'h00); wr(3'd2, 8'h00);
            pins[ln] = VECS[i][1];
            idle(4);
            exp = VECS[i][0] ? (8'h01 << ln[2:0]) : 8'h00;
            rd(ln < 8 ? 3'd0 : 3'd2, v);
            check(VECS[i][0] ? (VECS[i][3] ? "R1" : "R2") : "R3", v, exp);
            check("R6", {7'b0, irq}, 8'h00);
        end
        pins = '0; esel = '0;
        idle(6);
        clear_all();

        // R5 and R9: software set with enable raises irq one cycle later
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h01);
        #1;
        check("R9", {7'b0, irq}, 8'h00);
        @(negedge clk); #1;
        check("R5", {7'b0, irq}, 8'h01);
        // R4: flag persists
        idle(5);
        rd(3'd0, v);
        check("R4", v, 8'h01);
        wr(3'd0, 8'h00);
        rd(3'd0, v);
        check("R4", v, 8'h00);
        idle(2); #1;
        check("R9", {7'b0, irq}, 8'h00);
        clear_all();

        // R6: masked line still flags, irq follows enable
        pins[4] = 1'b1;
        idle(4);
        rd(3'd0, v);
        check("R6", v, 8'h10);
        check("R6", {7'b0, irq}, 8'h00);
        wr(3'd1, 8'h10);
        @(negedge clk); #1;
        check("R6", {7'b0, irq}, 8'h01);
        pins = '0;
        idle(6);
        clear_all();

        // R8: reserved bits of upper registers
        wr(3'd2, 8'hFF);
        rd(3'd2, v);
        check("R8", v, 8'h0F);
        wr(3'd3, 8'hFF);
        rd(3'd3, v);
        check("R8", v, 8'h0F);
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);

        // R12: unmapped addresses
        for (int a = 4; a < 8; a++) begin
            rd(3'(a), v);
            check("R12", v, 8'h00);
        end

        // R7: mid-run reset clears state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(3'd0, v); check("R7", v, 8'h00);
        rd(3'd3, v); check("R7", v, 8'h00);
        check("R7", {7'b0, irq}, 8'h00);
        idle(4);

        // R10: edge on line 3 coincides with a write of 0
        wr(3'd0, 8'h20);
        @(negedge clk);
        pins[3] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        addr = 3'd0; wdata = 8'h00; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
        rd(3'd0, v);
        check("R10", v, 8'h08);
        idle(4);
        clear_all();

        // R11: select flip on a steady high pin
        pins[9] = 1'b1;
        idle(6);
        wr(3'd2, 8'h00);
        esel[9] = 1'b1;
        idle(6);
        esel[9] = 1'b0;
        idle(6);
        rd(3'd2, v);
        check("R11", v, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule